// File: doc/BRIEF.md
# Physical Timer Compare Access Decoder

This block decides what happens when 32-bit code reads or writes the physical timer compare value. Its inputs describe the machine state: the current privilege level (0 to 3), which levels run with 32-bit execution, whether level 2 is enabled, whether level 3 exists, the two host-mode controls of the hypervisor, the security bit, and the access-enable bits held in the kernel and hypervisor timer controls. From these it produces one outcome. The access traps to level 1, traps to level 2, raises a 32-bit hypervisor trap, is undefined, or goes through to one of five compare-register banks.

The decision is an ordered first-match tree. The trap and undefined checks come first. Only an access that passes every check reaches bank steering. The outcome and its syndrome are captured in output registers, so they appear one clock after the inputs are sampled. Reads and writes use the same decode. The direction bit is carried alongside so the consumer knows which way the data moves.

Top module: `ptmr_access_decoder`

## Requirements
- R1: A synchronous active-high reset drives every output low at the next rising clock edge.
- R2: Outputs are registered and reflect the inputs sampled at the previous rising edge. From the second edge after reset is released, exactly one of the nine outcome lines is high: `trap_l1_q`, `trap_l2_q`, `trap_hyp32_q`, `undef_q`, and the five bits of `bank_sel_q`.
- R3: At level 0 the first check applies when level 1 is 64-bit, host mode (e2h=1 and tge=1 with level 2 enabled) is off, and `kern64_usr_en`=0. The access then traps with syndrome 0x04. It goes to level 2 when level 2 is enabled, 64-bit and tge=1, and to level 1 otherwise.
- R4: At level 0, when level 1 is 32-bit and `kern32_usr_en`=0, the outcome depends on level 2. If level 2 is enabled, 64-bit and tge=1, the access traps to level 2 with syndrome 0x04. If level 2 is enabled, 32-bit and tge=1, it raises a hypervisor trap with syndrome 0x00. Otherwise it is undefined.
- R5: At level 0 or 1, with level 2 enabled and 64-bit, e2h=0 and `hyp_cnt_en`=0, the access traps to level 2 with syndrome 0x04.
- R6: With level 2 enabled and 64-bit, two level-0 cases trap to level 2 with syndrome 0x04: e2h=1, tge=0 with `hyp_tmr_en`=0, and e2h=1, tge=1 with `hyp_usr_en`=0. At level 1, e2h=1 with `hyp_tmr_en`=0 traps the same way.
- R7: At level 0 or 1, with level 2 enabled and 32-bit and `hyp32_cnt_en`=0, the access raises a hypervisor trap with syndrome 0x04.
- R8: A level-0 access that passes its checks selects bank 3 (hypervisor secure) when level 2 is enabled and 64-bit in host mode with ns=0, and bank 4 (hypervisor non-secure) with ns=1. Otherwise it selects bank 0 (common). Bank index n is bit n of `bank_sel_q`: 0 common, 1 secure, 2 non-secure, 3 hypervisor secure, 4 hypervisor non-secure.
- R9: A level-1 access that passes its checks selects bank 2 when level 3 exists and runs 32-bit with ns=1, and bank 1 in that case with ns=0. Otherwise it selects bank 0.
- R10: Level 2 selects bank 2 when level 3 exists and runs 32-bit, and bank 0 otherwise. Level 3 selects bank 2 when ns=1 and bank 1 when ns=0. Neither level ever traps.
- R11: Checks are taken in the fixed order stated in R3 to R7. The first match decides, even when later checks would also match.
- R12: `synd_q` is 0 whenever a bank is selected or the access is undefined. The decode does not depend on `is_write`, and `wr_q` echoes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_lvl | input | 2 | Current privilege level |
| is_write | input | 1 | 1 for a write access, 0 for a read |
| l1_is32 | input | 1 | Level 1 runs 32-bit |
| l2_is32 | input | 1 | Level 2 runs 32-bit |
| l3_is32 | input | 1 | Level 3 runs 32-bit |
| l2_en | input | 1 | Level 2 enabled |
| l3_have | input | 1 | Level 3 exists |
| e2h | input | 1 | Hypervisor host-extension bit |
| tge | input | 1 | Hypervisor trap-general bit |
| ns | input | 1 | Non-secure state |
| kern64_usr_en | input | 1 | User timer access enable, 64-bit kernel control |
| kern32_usr_en | input | 1 | User timer access enable, 32-bit kernel control |
| hyp_cnt_en | input | 1 | Hypervisor counter enable for lower levels (64-bit) |
| hyp_tmr_en | input | 1 | Hypervisor timer enable for lower levels (64-bit) |
| hyp_usr_en | input | 1 | Hypervisor user timer enable in host mode (64-bit) |
| hyp32_cnt_en | input | 1 | Hypervisor counter enable, 32-bit level 2 |
| trap_l1_q | output | 1 | Trap to level 1 |
| trap_l2_q | output | 1 | Trap to level 2 |
| trap_hyp32_q | output | 1 | 32-bit hypervisor trap |
| undef_q | output | 1 | Undefined access |
| bank_sel_q | output | 5 | One-hot compare bank select |
| synd_q | output | 8 | Trap syndrome code |
| wr_q | output | 1 | Registered access direction |

## Verification
The hardest outcomes to reach are those where several checks could match at once. Examples are a level-0 access with level 1 32-bit whose user enable and a hypervisor enable are both clear, and host mode that turns off the first 64-bit user check while still steering the bank. A random walk seldom lines these up with the right level-2 width and tge value. The stimulus sweeps all 65536 combinations of level and control bits against an independent reference tree, toggling the direction bit by parity. Directed vectors come first and pin the priority cases.

// File: rtl/ptmr_dec_pkg.sv
package ptmr_dec_pkg;

  typedef enum logic [2:0] {
    OUT_SEL   = 3'd0,
    OUT_TRAP1 = 3'd1,
    OUT_TRAP2 = 3'd2,
    OUT_HYP32 = 3'd3,
    OUT_UNDEF = 3'd4
  } outcome_e;

  localparam int NUM_BANKS = 5;
  localparam int BANK_W    = $clog2(NUM_BANKS);

  typedef enum logic [BANK_W-1:0] {
    BK_COMMON = 3'd0,
    BK_SEC    = 3'd1,
    BK_NSEC   = 3'd2,
    BK_HYP_S  = 3'd3,
    BK_HYP_NS = 3'd4
  } bank_e;

  typedef struct packed {
    logic l1_is32;
    logic l2_is32;
    logic l3_is32;
    logic l2_en;
    logic l3_have;
    logic e2h;
    logic tge;
    logic ns;
    logic k64_usr;
    logic k32_usr;
    logic h_cnt;
    logic h_tmr;
    logic h_usr;
    logic h32_cnt;
  } ctl_t;

endpackage

// File: rtl/ptmr_gate_chk.sv
module ptmr_gate_chk
  import ptmr_dec_pkg::*;
#(
  parameter int SYND_W = 8
) (
  input  logic [1:0]        lvl,
  input  ctl_t              c,
  output outcome_e          res,
  output logic [SYND_W-1:0] synd
);
  localparam logic [SYND_W-1:0] CODE_CTR  = SYND_W'(4);
  localparam logic [SYND_W-1:0] CODE_NONE = '0;

  logic l2_64, l2_32, host;
  assign l2_64 = c.l2_en && !c.l2_is32;
  assign l2_32 = c.l2_en &&  c.l2_is32;
  assign host  = c.e2h && c.tge;

  always_comb begin
    res  = OUT_SEL;
    synd = CODE_NONE;
    unique case (lvl)
      2'd0: begin
        if (!c.l1_is32 && !(c.l2_en && host) && !c.k64_usr) begin
          res  = (l2_64 && c.tge) ? OUT_TRAP2 : OUT_TRAP1;
          synd = CODE_CTR;
        end else if (c.l1_is32 && !c.k32_usr) begin
          if (l2_64 && c.tge) begin
            res  = OUT_TRAP2;
            synd = CODE_CTR;
          end else if (l2_32 && c.tge) begin
            res  = OUT_HYP32;
            synd = CODE_NONE;
          end else begin
            res  = OUT_UNDEF;
          end
        end else if (l2_64 && !c.e2h && !c.h_cnt) begin
          res  = OUT_TRAP2;
          synd = CODE_CTR;
        end else if (l2_64 && c.e2h && !c.tge && !c.h_tmr) begin
          res  = OUT_TRAP2;
          synd = CODE_CTR;
        end else if (l2_64 && host && !c.h_usr) begin
          res  = OUT_TRAP2;
          synd = CODE_CTR;
        end else if (l2_32 && !c.h32_cnt) begin
          res  = OUT_HYP32;
          synd = CODE_CTR;
        end
      end
      2'd1: begin
        if (l2_64 && !c.e2h && !c.h_cnt) begin
          res  = OUT_TRAP2;
          synd = CODE_CTR;
        end else if (l2_64 && c.e2h && !c.h_tmr) begin
          res  = OUT_TRAP2;
          synd = CODE_CTR;
        end else if (l2_32 && !c.h32_cnt) begin
          res  = OUT_HYP32;
          synd = CODE_CTR;
        end
      end
      default: begin
        res  = OUT_SEL;
        synd = CODE_NONE;
      end
    endcase
  end
endmodule

// File: rtl/ptmr_bank_steer.sv
module ptmr_bank_steer
  import ptmr_dec_pkg::*;
(
  input  logic [1:0] lvl,
  input  ctl_t       c,
  output bank_e      bank
);
  logic l3_narrow, host64;
  assign l3_narrow = c.l3_have && c.l3_is32;
  assign host64    = c.l2_en && !c.l2_is32 && c.e2h && c.tge;

  always_comb begin
    unique case (lvl)
      2'd0:    bank = host64 ? (c.ns ? BK_HYP_NS : BK_HYP_S) : BK_COMMON;
      2'd1:    bank = l3_narrow ? (c.ns ? BK_NSEC : BK_SEC) : BK_COMMON;
      2'd2:    bank = l3_narrow ? BK_NSEC : BK_COMMON;
      default: bank = c.ns ? BK_NSEC : BK_SEC;
    endcase
  end
endmodule

// File: rtl/ptmr_line_enc.sv
module ptmr_line_enc
  import ptmr_dec_pkg::*;
(
  input  outcome_e             res,
  input  bank_e                bank,
  output logic                 t1,
  output logic                 t2,
  output logic                 th,
  output logic                 ud,
  output logic [NUM_BANKS-1:0] sel
);
  assign t1 = (res == OUT_TRAP1);
  assign t2 = (res == OUT_TRAP2);
  assign th = (res == OUT_HYP32);
  assign ud = (res == OUT_UNDEF);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    assign sel[g] = (res == OUT_SEL) && (bank == BANK_W'(g));
  end
endmodule

// File: rtl/ptmr_access_decoder.sv
module ptmr_access_decoder
  import ptmr_dec_pkg::*;
#(
  parameter int SYND_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           cur_lvl,
  input  logic                 is_write,
  input  logic                 l1_is32,
  input  logic                 l2_is32,
  input  logic                 l3_is32,
  input  logic                 l2_en,
  input  logic                 l3_have,
  input  logic                 e2h,
  input  logic                 tge,
  input  logic                 ns,
  input  logic                 kern64_usr_en,
  input  logic                 kern32_usr_en,
  input  logic                 hyp_cnt_en,
  input  logic                 hyp_tmr_en,
  input  logic                 hyp_usr_en,
  input  logic                 hyp32_cnt_en,
  output logic                 trap_l1_q,
  output logic                 trap_l2_q,
  output logic                 trap_hyp32_q,
  output logic                 undef_q,
  output logic [NUM_BANKS-1:0] bank_sel_q,
  output logic [SYND_W-1:0]    synd_q,
  output logic                 wr_q
);
  ctl_t                 ctl;
  outcome_e             res;
  bank_e                bank;
  logic [SYND_W-1:0]    synd;
  logic                 t1, t2, th, ud;
  logic [NUM_BANKS-1:0] sel;
  logic                 live_q;

  assign ctl = '{l1_is32: l1_is32, l2_is32: l2_is32, l3_is32: l3_is32,
                 l2_en: l2_en, l3_have: l3_have, e2h: e2h, tge: tge, ns: ns,
                 k64_usr: kern64_usr_en, k32_usr: kern32_usr_en,
                 h_cnt: hyp_cnt_en, h_tmr: hyp_tmr_en, h_usr: hyp_usr_en,
                 h32_cnt: hyp32_cnt_en};

  ptmr_gate_chk #(.SYND_W(SYND_W)) u_gate (
    .lvl (cur_lvl),
    .c   (ctl),
    .res (res),
    .synd(synd)
  );

  ptmr_bank_steer u_steer (
    .lvl (cur_lvl),
    .c   (ctl),
    .bank(bank)
  );

  ptmr_line_enc u_enc (
    .res (res),
    .bank(bank),
    .t1  (t1),
    .t2  (t2),
    .th  (th),
    .ud  (ud),
    .sel (sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_l1_q    <= 1'b0;
      trap_l2_q    <= 1'b0;
      trap_hyp32_q <= 1'b0;
      undef_q      <= 1'b0;
      bank_sel_q   <= '0;
      synd_q       <= '0;
      wr_q         <= 1'b0;
      live_q       <= 1'b0;
    end else begin
      trap_l1_q    <= t1;
      trap_l2_q    <= t2;
      trap_hyp32_q <= th;
      undef_q      <= ud;
      bank_sel_q   <= sel;
      synd_q       <= synd;
      wr_q         <= is_write;
      live_q       <= 1'b1;
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    live_q |-> $countones({trap_l1_q, trap_l2_q, trap_hyp32_q, undef_q, bank_sel_q}) == 1); // R2

  AST_NO_SYND_ON_SEL: assert property (@(posedge clk) disable iff (rst)
    (|bank_sel_q || undef_q) |-> synd_q == '0); // R12

  AST_L1_TRAP_FROM_USER: assert property (@(posedge clk) disable iff (rst)
    live_q && trap_l1_q |-> $past(cur_lvl) == 2'd0); // R3

  AST_TOP_LEVELS_SELECT: assert property (@(posedge clk) disable iff (rst)
    live_q && $past(cur_lvl[1]) |-> |bank_sel_q); // R10

  AST_UNDEF_NARROW_KERNEL: assert property (@(posedge clk) disable iff (rst)
    live_q && undef_q |-> $past(cur_lvl) == 2'd0 && $past(l1_is32) && !$past(kern32_usr_en)); // R4

  AST_DIR_ECHO: assert property (@(posedge clk) disable iff (rst)
    live_q |-> wr_q == $past(is_write)); // R12

endmodule

// File: tb/ptmr_access_decoder_test.sv
module ptmr_access_decoder_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [15:0] vin = '0;
  logic        wr_in = 1'b0;
  logic        t1, t2, th, ud, wr_o;
  logic [4:0]  sel;
  logic [7:0]  syn;

  int checks = 0;
  int errors = 0;

  ptmr_access_decoder uut (
    .clk(clk), .rst(rst), .cur_lvl(vin[1:0]), .is_write(wr_in),
    .l1_is32(vin[2]), .l2_is32(vin[3]), .l3_is32(vin[4]), .l2_en(vin[5]),
    .l3_have(vin[6]), .e2h(vin[7]), .tge(vin[8]), .ns(vin[9]),
    .kern64_usr_en(vin[10]), .kern32_usr_en(vin[11]), .hyp_cnt_en(vin[12]),
    .hyp_tmr_en(vin[13]), .hyp_usr_en(vin[14]), .hyp32_cnt_en(vin[15]),
    .trap_l1_q(t1), .trap_l2_q(t2), .trap_hyp32_q(th), .undef_q(ud),
    .bank_sel_q(sel), .synd_q(syn), .wr_q(wr_o)
  );

  localparam logic [15:0] LV0 = 16'd0, LV1 = 16'd1, LV2 = 16'd2, LV3 = 16'd3;
  localparam logic [15:0] L132 = 16'h0004, L232 = 16'h0008, L332 = 16'h0010;
  localparam logic [15:0] EN2 = 16'h0020, L3H = 16'h0040, E2H = 16'h0080;
  localparam logic [15:0] TGE = 16'h0100, NSB = 16'h0200, K64 = 16'h0400;
  localparam logic [15:0] K32 = 16'h0800, HCNT = 16'h1000, HTMR = 16'h2000;
  localparam logic [15:0] HUSR = 16'h4000, H32C = 16'h8000;
  localparam logic [15:0] ALLEN = K64 | K32 | HCNT | HTMR | HUSR | H32C;

  localparam int NDIR = 17;
  // {inputs, outcome (0 sel,1 L1,2 L2,3 hyp32,4 undef), bank, syndrome}
  localparam logic [29:0] DIR_TBL [NDIR] = '{
    {LV0 | (ALLEN & ~K64),                         3'd1, 3'd0, 8'h04},
    {LV0 | EN2 | TGE | (ALLEN & ~K64),             3'd2, 3'd0, 8'h04},
    {LV0 | EN2 | E2H | TGE | (ALLEN & ~K64),       3'd0, 3'd3, 8'h00},
    {LV0 | EN2 | E2H | TGE | NSB | (ALLEN & ~K64), 3'd0, 3'd4, 8'h00},
    {LV0 | L132 | L232 | EN2 | TGE | (ALLEN & ~K32), 3'd3, 3'd0, 8'h00},
    {LV0 | L132 | (ALLEN & ~K32),                  3'd4, 3'd0, 8'h00},
    {LV0 | L132 | EN2 | TGE | (ALLEN & ~K32),      3'd2, 3'd0, 8'h04},
    {LV0 | EN2 | (ALLEN & ~HCNT),                  3'd2, 3'd0, 8'h04},
    {LV0 | EN2 | E2H | (ALLEN & ~HTMR),            3'd2, 3'd0, 8'h04},
    {LV0 | L132 | L232 | EN2 | (ALLEN & ~H32C),    3'd3, 3'd0, 8'h04},
    {LV1 | EN2 | E2H | (ALLEN & ~HTMR),            3'd2, 3'd0, 8'h04},
    {LV1 | L3H | L332 | NSB | ALLEN,               3'd0, 3'd2, 8'h00},
    {LV1 | ALLEN,                                  3'd0, 3'd0, 8'h00},
    {LV2 | L3H | L332 | ALLEN,                     3'd0, 3'd2, 8'h00},
    {LV3,                                          3'd0, 3'd1, 8'h00},
    {LV0,                                          3'd1, 3'd0, 8'h04},
    {LV1 | EN2 | (ALLEN & ~HCNT),                  3'd2, 3'd0, 8'h04}
  };
  localparam string DIR_TAG [NDIR] = '{
    "R3", "R3", "R8", "R8", "R4", "R4", "R4", "R5", "R6", "R7",
    "R6", "R9", "R9", "R10", "R10", "R11", "R5"
  };

  // independent reference: returns {outcome, bank, syndrome}
  function automatic logic [13:0] ref_dec(input logic [15:0] v);
    logic [1:0] lv;
    logic a64, a32, hm;
    logic [2:0] o, b;
    logic [7:0] s;
    lv = v[1:0];
    a64 = v[5] && !v[3];
    a32 = v[5] && v[3];
    hm  = v[7] && v[8];
    o = 3'd0; b = 3'd0; s = 8'h00;
    if (lv == 2'd0) begin
      if (!v[2] && !(v[5] && hm) && !v[10]) begin o = (a64 && v[8]) ? 3'd2 : 3'd1; s = 8'h04; end
      else if (v[2] && !v[11]) begin
        if (a64 && v[8]) begin o = 3'd2; s = 8'h04; end
        else if (a32 && v[8]) o = 3'd3;
        else o = 3'd4;
      end
      else if (a64 && !v[7] && !v[12]) begin o = 3'd2; s = 8'h04; end
      else if (a64 && v[7] && !v[8] && !v[13]) begin o = 3'd2; s = 8'h04; end
      else if (a64 && hm && !v[14]) begin o = 3'd2; s = 8'h04; end
      else if (a32 && !v[15]) begin o = 3'd3; s = 8'h04; end
      else b = (a64 && hm) ? (v[9] ? 3'd4 : 3'd3) : 3'd0;
    end else if (lv == 2'd1) begin
      if (a64 && !v[7] && !v[12]) begin o = 3'd2; s = 8'h04; end
      else if (a64 && v[7] && !v[13]) begin o = 3'd2; s = 8'h04; end
      else if (a32 && !v[15]) begin o = 3'd3; s = 8'h04; end
      else b = (v[6] && v[4]) ? (v[9] ? 3'd2 : 3'd1) : 3'd0;
    end else if (lv == 2'd2) b = (v[6] && v[4]) ? 3'd2 : 3'd0;
    else b = v[9] ? 3'd2 : 3'd1;
    return {o, b, s};
  endfunction

  function automatic logic [16:0] lines(input logic [2:0] o, input logic [2:0] b, input logic [7:0] s);
    logic [4:0] bs;
    bs = (o == 3'd0) ? (5'd1 << b) : 5'd0;
    return {bs, o == 3'd4, o == 3'd3, o == 3'd2, o == 3'd1, s};
  endfunction

  task automatic compare(input string tag, input logic [16:0] exp);
    logic [16:0] act;
    act = {sel, ud, th, t2, t1, syn};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s in=%h act=%h exp=%h", tag, vin, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] v, input logic w);
    @(negedge clk);
    vin = v;
    wr_in = w;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [13:0] r;
    repeat (3) @(negedge clk);
    // R1: reset state
    compare("R1", 17'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NDIR; i++) begin
      apply(DIR_TBL[i][29:14], 1'b0);
      compare(DIR_TAG[i], lines(DIR_TBL[i][13:11], DIR_TBL[i][10:8], DIR_TBL[i][7:0]));
    end

    // R1: reset mid-run clears registered outputs
    @(negedge clk);
    rst = 1'b1;
    vin = LV0;
    @(negedge clk);
    compare("R1", 17'd0);
    rst = 1'b0;
    @(negedge clk);

    // exhaustive sweep against the reference; R2 one-hot, R12 direction
    for (int i = 0; i < 65536; i++) begin
      apply(16'(i), ^16'(i));
      r = ref_dec(16'(i));
      compare("R11", lines(r[13:11], r[10:8], r[7:0]));
      checks++;
      if ($countones({sel, ud, th, t2, t1}) != 1) begin
        errors++;
        $display("FAIL R2 in=%h act=%0d expected 1 line", vin, $countones({sel, ud, th, t2, t1}));
      end
      checks++;
      if (wr_o !== ^16'(i)) begin
        errors++;
        $display("FAIL R12 in=%h act=%b exp=%b", vin, wr_o, ^16'(i));
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule